// File: doc/BRIEF.md
# Broadcast-Input Multiply-Accumulate Layer

This block computes one fully connected layer by streaming the input vector in one element per accepted cycle and broadcasting each element to a bank of parallel multiply-accumulate lanes. There is one lane per output node. Each lane owns a local weight store with one entry per input position. On every accepted input, each lane reads the weight for the current position, multiplies it by the broadcast element and adds the product to its running sum. When the last element of a vector has been taken, every lane's complete inner product is copied into a holding register. The results can then be read through a lane-select port while the next vector is already accumulating.

The vector length is set at run time as a last-index value and may be anything from 1 up to the depth of the weight stores. Weights are loaded one word at a time by lane and position. The accumulators need no explicit clear: the first element of each vector starts a fresh sum. The product width and the accumulator width grow from the parameters so that a full-depth vector of extreme values cannot overflow.

Top module: `tmi_accum_array`

## Requirements
- R1: After reset, res_valid is 0, every lane reads 0 on res_data, the input position is 0, and the last index is MAX_DEPTH-1.
- R2: For a vector of N = last index + 1 accepted inputs x[0..N-1], lane u reports the signed sum over i of W[u][i]*x[i]. Inputs and weights are two's-complement signed, and res_data is a two's-complement value ACC_W bits wide.
- R3: res_valid is high for exactly the clock cycle that follows the edge at which the Nth input of a vector was accepted. The new results are readable in that same cycle, and res_valid is low after every other edge.
- R4: The first input of each vector starts a fresh sum, so back-to-back vectors with no idle cycle between them give independent results.
- R5: Cycles with in_valid low are ignored: they neither advance the input position nor change any sum or result.
- R6: A cycle with cfg_we high loads cfg_last as the new last index and returns the input position to 0, which discards any partial vector. An input presented in that same cycle is dropped.
- R7: The holding registers keep the previous vector's results unchanged while the next vector accumulates, until that vector completes.
- R8: A cycle with wr_en high writes wr_data to position wr_addr of lane wr_unit only. Vectors accepted afterwards use the new weight.
- R9: A full-depth vector (N = MAX_DEPTH) of extreme values (-128 times -128, or -128 times 127) gives the exact sum without overflow.
- R10: With a last index of 0 (N = 1), every accepted input completes a vector, and each lane reports W[u][0]*x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the last index and restart the vector |
| cfg_last | input | IDX_W | Last input position (N-1) |
| wr_en | input | 1 | Weight write strobe |
| wr_unit | input | UNIT_W | Lane that receives the weight |
| wr_addr | input | IDX_W | Input position of the weight |
| wr_data | input | W_W | Signed weight value |
| in_valid | input | 1 | An input element is presented |
| in_data | input | IN_W | Signed input element, broadcast to all lanes |
| res_valid | output | 1 | Pulse: a vector has just completed |
| res_sel | input | UNIT_W | Lane whose held result appears on res_data |
| res_data | output | ACC_W | Held signed inner product of the selected lane |

## Verification
The bench targets the boundary of a vector. A design that failed to clear the sum on the first element would carry the previous vector into the next back-to-back result. A design with an off-by-one last-index compare would pulse res_valid one input early or late, which would be most visible at N = 1, where it must pulse on every input. It also checks an abort by a length write in the middle of a vector: a design that kept the partial position would misalign all later weights. Full-depth vectors of extreme values expose an accumulator that is too narrow or sign-extends wrongly. Reading results while the next vector runs catches holding registers that track the live accumulators.

// File: rtl/tmi_pkg.sv
`timescale 1ns/1ps
package tmi_pkg;
   // Width of a running sum that can absorb depth full-scale products
   function automatic int sum_width(input int in_w, input int w_w, input int depth);
      return in_w + w_w + $clog2(depth);
   endfunction

   // Width of an index able to address depth entries
   function automatic int index_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/tmi_index_ctrl.sv
`timescale 1ns/1ps
module tmi_index_ctrl #(
   parameter int MAX_DEPTH = 512,
   parameter int IDX_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_last,
   input  logic             in_valid,
   output logic [IDX_W-1:0] cur_idx,
   output logic [IDX_W-1:0] last_q,
   output logic             take,
   output logic             first,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(MAX_DEPTH - 1);

   assign take  = in_valid & ~cfg_we;
   assign first = (cur_idx == '0);
   assign done  = take & (cur_idx == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx <= '0;
         last_q  <= LAST_RST;
      end else if (cfg_we) begin
         cur_idx <= '0;
         last_q  <= cfg_last;
      end else if (take) begin
         cur_idx <= done ? '0 : cur_idx + 1'b1;
      end
   end
endmodule

// File: rtl/tmi_weight_bank.sv
`timescale 1ns/1ps
module tmi_weight_bank #(
   parameter int DEPTH = 512,
   parameter int W_W   = 8,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [W_W-1:0]   wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [W_W-1:0]   rdata
);
   logic [W_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/tmi_mac_lane.sv
`timescale 1ns/1ps
module tmi_mac_lane #(
   parameter int DEPTH = 512,
   parameter int IN_W  = 8,
   parameter int W_W   = 8,
   parameter int IDX_W = 9,
   parameter int ACC_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [W_W-1:0]   wr_data,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [IN_W-1:0]  x,
   input  logic             take,
   input  logic             first,
   input  logic             done,
   output logic [ACC_W-1:0] held
);
   localparam int PROD_W = IN_W + W_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   logic [W_W-1:0]           w_raw;
   logic signed [PROD_W-1:0] prod;
   logic [ACC_W-1:0]         prod_ext;
   logic [ACC_W-1:0]         acc_q;
   logic [ACC_W-1:0]         acc_d;

   tmi_weight_bank #(.DEPTH(DEPTH), .W_W(W_W), .IDX_W(IDX_W)) i_bank (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (cur_idx),
      .rdata (w_raw)
   );

   assign prod     = $signed(x) * $signed(w_raw);
   assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
   assign acc_d    = (first ? '0 : acc_q) + prod_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         held  <= '0;
      end else if (take) begin
         acc_q <= acc_d;
         if (done) held <= acc_d;
      end
   end
endmodule

// File: rtl/tmi_accum_array.sv
`timescale 1ns/1ps
module tmi_accum_array #(
   parameter int NUM_UNITS = 4,
   parameter int MAX_DEPTH = 512,
   parameter int IN_W      = 8,
   parameter int W_W       = 8,
   parameter int IDX_W     = tmi_pkg::index_width(MAX_DEPTH),
   parameter int UNIT_W    = tmi_pkg::index_width(NUM_UNITS),
   parameter int ACC_W     = tmi_pkg::sum_width(IN_W, W_W, MAX_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_last,
   input  logic              wr_en,
   input  logic [UNIT_W-1:0] wr_unit,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [W_W-1:0]    wr_data,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   output logic              res_valid,
   input  logic [UNIT_W-1:0] res_sel,
   output logic [ACC_W-1:0]  res_data
);
   // Elaboration-time parameter checks
   if (NUM_UNITS < 2) begin : g_bad_units
      $error("tmi_accum_array: NUM_UNITS must be at least 2");
   end
   if (MAX_DEPTH < 2) begin : g_bad_depth
      $error("tmi_accum_array: MAX_DEPTH must be at least 2");
   end
   if (ACC_W < tmi_pkg::sum_width(IN_W, W_W, MAX_DEPTH)) begin : g_bad_acc
      $error("tmi_accum_array: ACC_W too narrow for MAX_DEPTH");
   end
   if ((1 << IDX_W) < MAX_DEPTH) begin : g_bad_idx
      $error("tmi_accum_array: IDX_W cannot address MAX_DEPTH");
   end

   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] last_q;
   logic             take;
   logic             first;
   logic             done;
   logic [ACC_W-1:0] lane_res [NUM_UNITS];

   tmi_index_ctrl #(.MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_last (cfg_last),
      .in_valid (in_valid),
      .cur_idx  (cur_idx),
      .last_q   (last_q),
      .take     (take),
      .first    (first),
      .done     (done)
   );

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
      logic lane_we;
      assign lane_we = wr_en & (wr_unit == UNIT_W'(u));

      tmi_mac_lane #(
         .DEPTH (MAX_DEPTH),
         .IN_W  (IN_W),
         .W_W   (W_W),
         .IDX_W (IDX_W),
         .ACC_W (ACC_W)
      ) i_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (lane_we),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .cur_idx (cur_idx),
         .x       (in_data),
         .take    (take),
         .first   (first),
         .done    (done),
         .held    (lane_res[u])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_valid <= 1'b0;
      else        res_valid <= done;
   end

   always_comb begin
      res_data = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (res_sel == UNIT_W'(u)) res_data = lane_res[u];
      end
   end
endmodule

// File: rtl/tmi_accum_array_chk.sv
`timescale 1ns/1ps
module tmi_accum_array_chk #(
   parameter int IDX_W  = 9,
   parameter int UNIT_W = 2,
   parameter int ACC_W  = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [IDX_W-1:0]  cfg_last,
   input logic              in_valid,
   input logic              res_valid,
   input logic [UNIT_W-1:0] res_sel,
   input logic [ACC_W-1:0]  res_data,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [IDX_W-1:0]  last_q
);
   a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cur_idx <= last_q);

   a_r3_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_we && cur_idx == last_q) |=> res_valid);

   a_r3_pulse_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid && !cfg_we && cur_idx == last_q));

   a_r5_idle_holds_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !cfg_we) |=> $stable(cur_idx));

   a_r6_cfg_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cur_idx == '0 && last_q == $past(cfg_last)));

   a_r7_results_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && $stable(res_sel)) |-> $stable(res_data));
endmodule

bind tmi_accum_array tmi_accum_array_chk #(
   .IDX_W  (IDX_W),
   .UNIT_W (UNIT_W),
   .ACC_W  (ACC_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_last  (cfg_last),
   .in_valid  (in_valid),
   .res_valid (res_valid),
   .res_sel   (res_sel),
   .res_data  (res_data),
   .cur_idx   (cur_idx),
   .last_q    (last_q)
);

// File: tb/test_tmi_accum_array.sv
`timescale 1ns/1ps
module test_tmi_accum_array;
   localparam int M     = 4;
   localparam int DEPTH = 512;
   localparam int IDX_W = 9;
   localparam int UW    = 2;
   localparam int ACC_W = 25;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [IDX_W-1:0] cfg_last = '0;
   logic             wr_en = 1'b0;
   logic [UW-1:0]    wr_unit = '0;
   logic [IDX_W-1:0] wr_addr = '0;
   logic [7:0]       wr_data = '0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = '0;
   logic             res_valid;
   logic [UW-1:0]    res_sel = '0;
   logic [ACC_W-1:0] res_data;

   int     n_tests = 0;
   int     n_fail  = 0;
   bit     finished = 1'b0;
   int     wmod [M][DEPTH];
   int     xbuf [DEPTH];
   longint held_exp [M];
   int     mlen = DEPTH;

   always #10 clk = ~clk;

   tmi_accum_array i_tmi_accum_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_last(cfg_last),
      .wr_en(wr_en), .wr_unit(wr_unit), .wr_addr(wr_addr), .wr_data(wr_data),
      .in_valid(in_valid), .in_data(in_data), .res_valid(res_valid),
      .res_sel(res_sel), .res_data(res_data)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint dot(input int u, input int n);
      longint s = 0;
      for (int i = 0; i < n; i++) s += longint'(wmod[u][i]) * longint'(xbuf[i]);
      return s;
   endfunction

   task automatic write_w(input int u, input int a, input int v);
      wr_en = 1'b1; wr_unit = UW'(u); wr_addr = IDX_W'(a); wr_data = 8'(v);
      @(negedge clk);
      wr_en = 1'b0;
      wmod[u][a] = v;
   endtask

   task automatic set_len(input int n);
      cfg_we = 1'b1; cfg_last = IDX_W'(n - 1);
      @(negedge clk);
      cfg_we = 1'b0;
      mlen = n;
   endtask

   // Read all held results and compare with the given expectations
   task automatic read_all(input string req);
      for (int u = 0; u < M; u++) begin
         res_sel = UW'(u);
         #1;
         check(req, longint'($signed(res_data)), held_exp[u]);
      end
   endtask

   // Feed count elements of the current vector starting at position start
   task automatic feed(input int start, input int count, input int mode, input bit gaps);
      for (int i = start; i < start + count; i++) begin
         int x;
         case (mode)
            1:       x = -128;
            default: x = int'($signed(8'($urandom)));
         endcase
         xbuf[i] = x;
         if (gaps && $urandom_range(0, 2) == 0) begin
            @(negedge clk);
            @(negedge clk);
         end
         in_valid = 1'b1; in_data = 8'(x);
         @(negedge clk);
         in_valid = 1'b0;
         if (i != mlen - 1) check("R3 no early pulse", longint'(res_valid), 0);
      end
   endtask

   task automatic run_vec(input string req, input int mode, input bit gaps);
      feed(0, mlen, mode, gaps);
      check({req, " R3 pulse"}, longint'(res_valid), 1);
      for (int u = 0; u < M; u++) held_exp[u] = dot(u, mlen);
      read_all({req, " R2 sums"});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #45 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 res_valid", longint'(res_valid), 0);
      for (int u = 0; u < M; u++) held_exp[u] = 0;
      read_all("R1 held zero");

      // R8: program every weight
      for (int u = 0; u < M; u++)
         for (int a = 0; a < DEPTH; a++)
            write_w(u, a, int'($signed(8'($urandom))));

      // R2 R3: short vector, no gaps
      set_len(8);
      run_vec("R2 dense", 0, 1'b0);
      // R5: idle cycles between inputs
      run_vec("R5 gaps", 0, 1'b1);
      // R4: back-to-back vectors (no idle cycle after the pulse)
      feed(0, mlen, 0, 1'b0);
      for (int u = 0; u < M; u++) held_exp[u] = dot(u, mlen);
      feed(0, mlen, 0, 1'b0);
      check("R4 pulse", longint'(res_valid), 1);
      for (int u = 0; u < M; u++) held_exp[u] = dot(u, mlen);
      read_all("R4 fresh sum");

      // R7: partial vector leaves held results alone
      feed(0, 3, 0, 1'b0);
      check("R7 no pulse", longint'(res_valid), 0);
      read_all("R7 held stable");
      // R6: length write aborts the partial vector; same-cycle input dropped
      cfg_we = 1'b1; cfg_last = IDX_W'(4); in_valid = 1'b1; in_data = 8'd77;
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0; mlen = 5;
      check("R6 no pulse on cfg", longint'(res_valid), 0);
      run_vec("R6 restart", 0, 1'b0);

      // R10: single-element vectors
      set_len(1);
      for (int k = 0; k < 3; k++) run_vec("R10 n1", 0, 1'b0);

      // R8: rewrite one weight of lane 2, others untouched
      write_w(2, 0, -77);
      run_vec("R8 new weight", 0, 1'b0);

      // R9: full-depth extreme values
      for (int u = 0; u < M; u++)
         for (int a = 0; a < DEPTH; a++)
            write_w(u, a, (u % 2 == 0) ? -128 : 127);
      set_len(DEPTH);
      run_vec("R9 extreme", 1, 1'b0);
      check("R9 lane0 value", held_exp[0], 64'sd8388608);
      check("R9 lane1 value", held_exp[1], -64'sd8323072);

      // Random lengths, weights and gaps
      for (int a = 0; a < 64; a++)
         for (int u = 0; u < M; u++)
            write_w(u, a, int'($signed(8'($urandom))));
      for (int k = 0; k < 20; k++) begin
         set_len($urandom_range(1, 64));
         run_vec("R2 random", 0, 1'($urandom_range(0, 1)));
      end

      @(negedge clk);
      check("R3 pulse drops", longint'(res_valid), 0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule